// File: doc/BRIEF.md
# CEC Transmit Message Staging Controller

This block holds one outgoing consumer-electronics-control message while a bit-level line driver sends it. Software fills a small register file with the sender's logical address, the target's logical address, an opcode and up to fourteen operand bytes, then fires the message with a single trigger write. A header-only poll message, used to probe whether an address is taken, is fired by a flag in the target-address write itself.

Once fired, the controller hands the frame out one byte at a time over a valid/ready handshake. It tags the final byte and then waits for the line driver's verdict. A negative acknowledge restarts the whole frame from its header byte, up to a programmable number of attempts. The controller then raises a success flag or an attempts-exhausted flag. Each flag has an interrupt enable, and software clears each flag by writing 1 to it. A self-clearing flush bit empties the staged content and abandons a message that is in progress.

Top module: `cec_tx_stager`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `ftx_valid` is 0.
- R2: The sender address (0x00, bits 3:0), target address (0x04, bits 3:0), opcode (0x08) and operand byte i (0x40 + 4*i, i = 0..13) read back the values last written.
- R3: Writing 0x10 with bit 4 set launches a frame of header byte {sender, target}, then the opcode, then N operands in index order, where N is bits 3:0 clamped to 14. `ftx_last` is high on the final byte only.
- R4: Writing 0x04 with bit 7 set launches a one-byte frame holding only the header, marked last.
- R5: Bit 4 of 0x10 reads 1 while a message is in progress. During that time, writes to 0x00, 0x04, 0x08, 0x10 and the operand words are ignored, and this includes trigger writes.
- R6: While `ftx_valid` is high and `ftx_ready` is low, the byte and its last flag hold steady.
- R7: An acknowledge result ends the message and sets bit 5 of the status word at 0x14.
- R8: Bits 6:4 of 0x0C set the attempt limit minus one. A negative acknowledge resends the whole frame until that many attempts have failed, then sets bit 1 of the status word at 0x18. After a message, the same field reads back the attempts made minus one.
- R9: Writing 1 to a status bit clears it. Writing 0 to it leaves it unchanged.
- R10: `irq` is high exactly when a status bit and its enable are both set. The enables are bit 5 of 0x1C and bit 1 of 0x20.
- R11: Writing bit 7 of 0x0C makes that bit read 1 for one cycle, after which it reads 0. The flush zeroes the opcode, the operands and the operand count, drops any message in progress, and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address, word aligned |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |
| ftx_valid | output | 1 | Frame byte offered to line driver |
| ftx_byte | output | 8 | Offered frame byte |
| ftx_last | output | 1 | Offered byte is the final one |
| ftx_ready | input | 1 | Line driver takes the byte |
| ftx_done | input | 1 | One-cycle attempt result strobe |
| ftx_ack | input | 1 | Result: 1 acknowledged, 0 negative acknowledge |

## Verification
The checker assumes the line driver raises `ftx_done` only after it has taken the last byte, and only once per attempt. A status flag can therefore only rise on such a strobe, and an offered byte can only change after it has been taken. The bench's line-driver model keeps to this. It counts down from the accepted last byte before it pulses the result, and it moves `ftx_ready` only at falling edges, either steadily high or toggling to force stalls. Register writes are also kept to word-aligned addresses.

// File: rtl/cec_tx_stager.sv
`timescale 1ns/1ps
module cec_tx_stager #(
  parameter int AW = 8,
  parameter int MAX_OPS = 14,
  parameter int LIM_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          ftx_valid,
  output logic [7:0]    ftx_byte,
  output logic          ftx_last,
  input  logic          ftx_ready,
  input  logic          ftx_done,
  input  logic          ftx_ack
);
  localparam int IDX_W = $clog2(MAX_OPS + 3);
  localparam int OIW = $clog2(MAX_OPS);
  localparam logic [AW-1:0] A_SRC = 'h00, A_DST = 'h04, A_OPC = 'h08, A_CTL = 'h0C,
                            A_GO = 'h10, A_ST0 = 'h14, A_ST1 = 'h18, A_EN0 = 'h1C,
                            A_EN1 = 'h20, A_OPS = 'h40;
  localparam logic [AW-1:0] A_OPE = AW'(64 + 4 * MAX_OPS);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_t;
  st_t st;

  logic [3:0] src, dst, cnt;
  logic [7:0] opc;
  logic [7:0] ops [MAX_OPS];
  logic poll, flush_q, show_att, st_done, st_exh, en_done, en_exh;
  logic [LIM_W-1:0] lim_q, att_q;
  logic [IDX_W-1:0] idx;

  wire busy = (st != S_IDLE);
  wire op_hit = (reg_addr[1:0] == 2'b00) && (reg_addr >= A_OPS) && (reg_addr < A_OPE);
  wire [OIW-1:0] op_idx = OIW'((reg_addr - A_OPS) >> 2);
  wire stage_we = reg_we && !busy && !flush_q;
  wire go_wr = stage_we && reg_addr == A_GO && reg_wdata[4];
  wire poll_wr = stage_we && reg_addr == A_DST && reg_wdata[7];
  wire [3:0] cnt_in = (reg_wdata[3:0] > 4'(MAX_OPS)) ? 4'(MAX_OPS) : reg_wdata[3:0];
  wire [IDX_W-1:0] last_idx = poll ? '0 : IDX_W'(cnt) + IDX_W'(1);
  wire is_last = (idx == last_idx);
  wire [OIW-1:0] op_sel = OIW'(idx - IDX_W'(2));

  assign ftx_valid = (st == S_SEND);
  assign ftx_last = ftx_valid && is_last;
  assign ftx_byte = (idx == '0) ? {src, dst} : (idx == IDX_W'(1)) ? opc : ops[op_sel];
  assign irq = (st_done && en_done) || (st_exh && en_exh);

  always_comb begin
    reg_rdata = '0;
    if (op_hit) reg_rdata = ops[op_idx];
    else case (reg_addr)
      A_SRC: reg_rdata = {4'b0, src};
      A_DST: reg_rdata = {4'b0, dst};
      A_OPC: reg_rdata = opc;
      A_CTL: reg_rdata = {flush_q, show_att ? att_q : lim_q, 4'b0};
      A_GO:  reg_rdata = {3'b0, busy, cnt};
      A_ST0: reg_rdata = {2'b0, st_done, 5'b0};
      A_ST1: reg_rdata = {6'b0, st_exh, 1'b0};
      A_EN0: reg_rdata = {2'b0, en_done, 5'b0};
      A_EN1: reg_rdata = {6'b0, en_exh, 1'b0};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; src <= '0; dst <= '0; cnt <= '0; opc <= '0; poll <= 1'b0;
      for (int i = 0; i < MAX_OPS; i++) ops[i] <= '0;
      flush_q <= 1'b0; show_att <= 1'b0; lim_q <= '0; att_q <= '0; idx <= '0;
      st_done <= 1'b0; st_exh <= 1'b0; en_done <= 1'b0; en_exh <= 1'b0;
    end else begin
      if (stage_we) begin
        if (reg_addr == A_SRC) src <= reg_wdata[3:0];
        if (reg_addr == A_DST) begin dst <= reg_wdata[3:0]; poll <= reg_wdata[7]; end
        if (reg_addr == A_OPC) opc <= reg_wdata;
        if (reg_addr == A_GO) begin cnt <= cnt_in; if (reg_wdata[4]) poll <= 1'b0; end
        if (op_hit) ops[op_idx] <= reg_wdata;
      end
      if (reg_we && reg_addr == A_CTL) begin
        if (!busy) begin lim_q <= reg_wdata[6:4]; show_att <= 1'b0; end
        if (reg_wdata[7]) flush_q <= 1'b1;
      end
      if (reg_we && reg_addr == A_EN0) en_done <= reg_wdata[5];
      if (reg_we && reg_addr == A_EN1) en_exh <= reg_wdata[1];
      if (reg_we && reg_addr == A_ST0 && reg_wdata[5]) st_done <= 1'b0;
      if (reg_we && reg_addr == A_ST1 && reg_wdata[1]) st_exh <= 1'b0;
      case (st)
        S_IDLE: if (go_wr || poll_wr) begin
          st <= S_SEND; idx <= '0; att_q <= '0; show_att <= 1'b1;
        end
        S_SEND: if (ftx_ready) begin
          if (is_last) st <= S_WAIT;
          else idx <= idx + IDX_W'(1);
        end
        S_WAIT: if (ftx_done) begin
          if (ftx_ack) begin st_done <= 1'b1; st <= S_IDLE; end
          else if (att_q == lim_q) begin st_exh <= 1'b1; st <= S_IDLE; end
          else begin att_q <= att_q + LIM_W'(1); idx <= '0; st <= S_SEND; end
        end
        default: st <= S_IDLE;
      endcase
      if (flush_q) begin
        flush_q <= 1'b0; opc <= '0; cnt <= '0; poll <= 1'b0; st <= S_IDLE; idx <= '0;
        for (int i = 0; i < MAX_OPS; i++) ops[i] <= '0;
      end
    end
  end
endmodule

module cec_tx_stager_chk #(parameter int LIM_W = 3) (
  input logic clk, rst_n, ftx_valid, ftx_ready, ftx_last, ftx_done, ftx_ack,
  input logic [7:0] ftx_byte,
  input logic st_done, st_exh, flush_q, busy,
  input logic [LIM_W-1:0] att_q, lim_q
);
  assert_byte_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ftx_valid && !ftx_ready && !flush_q |=> ftx_valid && $stable(ftx_byte) && $stable(ftx_last));
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $past(ftx_done && ftx_ack));
  assert_exh_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_exh) |-> $past(ftx_done && !ftx_ack));
  assert_att_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> att_q <= lim_q);
  assert_flush_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q && !ftx_valid);
endmodule

bind cec_tx_stager cec_tx_stager_chk #(.LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ftx_valid(ftx_valid), .ftx_ready(ftx_ready),
  .ftx_last(ftx_last), .ftx_done(ftx_done), .ftx_ack(ftx_ack), .ftx_byte(ftx_byte),
  .st_done(st_done), .st_exh(st_exh), .flush_q(flush_q), .busy(busy),
  .att_q(att_q), .lim_q(lim_q));

// File: tb/cec_tx_stager_bench.sv
`timescale 1ns/1ps
module cec_tx_stager_bench;
  localparam logic [7:0] R_SRC = 8'h00, R_DST = 8'h04, R_OPC = 8'h08, R_CTL = 8'h0C,
                         R_GO = 8'h10, R_ST0 = 8'h14, R_ST1 = 8'h18, R_EN0 = 8'h1C,
                         R_EN1 = 8'h20, R_OPS = 8'h40;
  // {sender[27:24], target[23:20], opcode[19:12], count[11:8], first operand[7:0]}
  localparam logic [27:0] VEC [4] = '{
    {4'h4, 4'h0, 8'h36, 4'd0,  8'h00},
    {4'h1, 4'hF, 8'h82, 4'd2,  8'h10},
    {4'hA, 4'h3, 8'h44, 4'd7,  8'hC0},
    {4'h0, 4'h5, 8'h90, 4'd15, 8'h21}};

  logic clk = 0, rst_n = 0, reg_we = 0, irq, ftx_valid, ftx_last, ftx_ready = 1, ftx_done = 0, ftx_ack = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata, ftx_byte;
  int total = 0, bad = 0, nlog = 0, nlast = 0, wcnt = 0, ridx = 0;
  bit finished = 0, stall = 0, tog = 0, hold0 = 0;
  logic [7:0] log_b [64];
  bit resp [16];

  cec_tx_stager u_cec_tx_stager (.*);

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    ftx_done = 1'b0;
    tog = ~tog;
    ftx_ready = hold0 ? 1'b0 : (stall ? tog : 1'b1);
    if (ftx_valid && ftx_ready) begin
      if (nlog < 64) log_b[nlog] = ftx_byte;
      nlog++;
      if (ftx_last) begin nlast++; wcnt = 2; end
    end else if (wcnt > 0) begin
      wcnt--;
      if (wcnt == 0) begin ftx_done = 1'b1; ftx_ack = resp[ridx]; ridx++; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask
  task automatic wait_idle();
    logic [7:0] v;
    for (int k = 0; k < 3000; k++) begin @(negedge clk); rd(R_GO, v); if (!v[4]) break; end
  endtask
  task automatic clear_log();
    nlog = 0; nlast = 0; ridx = 0;
    for (int i = 0; i < 16; i++) resp[i] = 1'b1;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    foreach (VEC[i]) begin end
    rd(R_SRC, v); chk("R1 src", v, 0);
    rd(R_OPC, v); chk("R1 opc", v, 0);
    rd(R_CTL, v); chk("R1 ctl", v, 0);
    rd(R_GO, v);  chk("R1 go", v, 0);
    rd(R_ST0, v); chk("R1 st0", v, 0);
    rd(R_OPS + 8'd52, v); chk("R1 op13", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 valid", ftx_valid, 0);

    // R2 readback
    wr(R_SRC, 8'hF7); rd(R_SRC, v); chk("R2 src", v, 8'h07);
    wr(R_DST, 8'h3C); rd(R_DST, v); chk("R2 dst", v, 8'h0C);
    wr(R_OPS + 8'd52, 8'hA5); rd(R_OPS + 8'd52, v); chk("R2 op13", v, 8'hA5);

    // R3 / R6 / R7 vector table
    for (int n = 0; n < 4; n++) begin
      logic [27:0] e;
      int nop;
      e = VEC[n];
      nop = (e[11:8] > 14) ? 14 : int'(e[11:8]);
      stall = n[0];
      wr(R_SRC, {4'h0, e[27:24]}); wr(R_DST, {4'h0, e[23:20]}); wr(R_OPC, e[19:12]);
      for (int i = 0; i < nop; i++) wr(R_OPS + 8'(4 * i), e[7:0] + 8'(i));
      clear_log();
      wr(R_GO, {4'h1, e[11:8]});
      wait_idle();
      chk("R3 length", nlog, 2 + nop);
      chk("R3 last count", nlast, 1);
      chk("R3 header", log_b[0], {e[27:24], e[23:20]});
      chk("R3 opcode", log_b[1], e[19:12]);
      for (int i = 0; i < nop; i++) chk(stall ? "R6 operand" : "R3 operand", log_b[2 + i], e[7:0] + 8'(i));
      rd(R_ST0, v); chk("R7 done", v, 8'h20);
      wr(R_ST0, 8'h20);
    end
    stall = 0;

    // R4 poll
    wr(R_SRC, 8'h02); clear_log();
    wr(R_DST, 8'h85); wait_idle();
    chk("R4 length", nlog, 1);
    chk("R4 header", log_b[0], 8'h25);
    chk("R4 last", nlast, 1);

    // R9 / R10
    rd(R_ST0, v); chk("R7 poll done", v, 8'h20);
    wr(R_ST0, 8'h00); rd(R_ST0, v); chk("R9 w0 keeps", v, 8'h20);
    chk("R10 irq off when disabled", irq, 0);
    wr(R_EN0, 8'h20); #1; chk("R10 irq on", irq, 1);
    rd(R_EN0, v); chk("R10 en0", v, 8'h20);
    wr(R_ST0, 8'h20); rd(R_ST0, v); chk("R9 w1 clears", v, 0);
    chk("R10 irq after clear", irq, 0);

    // R5 busy blocking
    stall = 1;
    wr(R_OPC, 8'h11); wr(R_GO, 8'h13); clear_log();
    rd(R_GO, v); chk("R5 busy", v[4], 1);
    wr(R_OPC, 8'hEE); wr(R_GO, 8'h12); wr(R_DST, 8'h81);
    wait_idle();
    rd(R_OPC, v); chk("R5 opc kept", v, 8'h11);
    rd(R_GO, v); chk("R5 count kept", v, 8'h03);
    chk("R5 single frame", nlast, 1);
    stall = 0;
    wr(R_ST0, 8'h20); wr(R_EN0, 8'h00);

    // R8 exhaustion with limit 2 (3 attempts)
    wr(R_CTL, 8'h20); wr(R_GO, 8'h01);
    clear_log(); resp[0] = 0; resp[1] = 0; resp[2] = 0;
    wr(R_GO, 8'h11); wait_idle();
    chk("R8 resent bytes", nlog, 9);
    chk("R8 header resent", log_b[3], 8'h25);
    rd(R_ST1, v); chk("R8 exhausted", v, 8'h02);
    rd(R_ST0, v); chk("R8 no done", v, 0);
    rd(R_CTL, v); chk("R8 attempts field", v, 8'h20);
    wr(R_EN1, 8'h02); #1; chk("R10 irq exh", irq, 1);
    wr(R_ST1, 8'h02); #1; chk("R10 irq exh cleared", irq, 0);

    // R8 success on third attempt of four allowed
    wr(R_CTL, 8'h30); rd(R_CTL, v); chk("R8 limit readback", v, 8'h30);
    clear_log(); resp[0] = 0; resp[1] = 0;
    wr(R_GO, 8'h11); wait_idle();
    chk("R8 bytes", nlog, 9);
    rd(R_ST0, v); chk("R8 done late", v, 8'h20);
    rd(R_ST1, v); chk("R8 not exhausted", v, 0);
    rd(R_CTL, v); chk("R8 attempts made", v, 8'h20);
    wr(R_ST0, 8'h20);

    // R11 flush
    wr(R_OPC, 8'h55); wr(R_OPS, 8'h77);
    wr(R_CTL, 8'h80); rd(R_CTL, v); chk("R11 flush pending", v[7], 1);
    @(negedge clk); rd(R_CTL, v); chk("R11 flush self clears", v[7], 0);
    rd(R_OPC, v); chk("R11 opc zeroed", v, 0);
    rd(R_OPS, v); chk("R11 operand zeroed", v, 0);
    rd(R_GO, v); chk("R11 count zeroed", v, 0);
    hold0 = 1; clear_log();
    wr(R_GO, 8'h12);
    repeat (3) @(negedge clk);
    chk("R11 stalled valid", ftx_valid, 1);
    wr(R_CTL, 8'h80);
    repeat (3) @(negedge clk);
    chk("R11 abort valid", ftx_valid, 0);
    rd(R_GO, v); chk("R11 abort idle", v[4], 0);
    rd(R_ST0, v); chk("R11 no done", v, 0);
    rd(R_ST1, v); chk("R11 no exh", v, 0);
    hold0 = 0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule